// File: doc/BRIEF.md
# 1-Wire Bus Master

This block is a bit-level master for a single-wire open-drain bus. It produces the timed slots that such a bus uses: a long reset slot with a presence check, write slots for a one and for a zero, and read slots. The bus is never driven high. The block only pulls the line low through an output enable, and otherwise leaves the line released to an external pull-up. The line level is read back through a two-flop synchronizer.

A host issues one operation at a time on a small command port. The operations are: bus reset, write one bit, read one bit, write a byte, or read a byte. A start pulse while the block is idle launches the operation. The `busy` output then stays high until the last slot has finished its recovery time, and `done` pulses for one cycle. A bus reset returns an active-low presence flag: 1 means no device answered. A read returns the received data. All slot timings are whole microseconds, scaled by one parameter that gives clock cycles per microsecond.

Top module: `onewire_master`

## Requirements
- R1: A reset operation holds `line_oe` high for 480 us, then releases the line for 480 us. The slot is 960 us long.
- R2: The reset result is the synchronized line level sampled 70 us after release. `presence_n` is 1 when no device pulled the line low and 0 when one did. It updates in the cycle `done` is high.
- R3: A write-one slot (op 1 with `cmd_wdata[0]`=1) holds `line_oe` high for 6 us, then releases it for 64 us.
- R4: A write-zero slot (op 1 with `cmd_wdata[0]`=0) holds `line_oe` high for 60 us, then releases it for 10 us.
- R5: A read slot (op 2) holds `line_oe` high for 6 us, samples the line 9 us after release, and ends 55 us later, so the slot is 70 us long. The bit is returned in `rd_data[0]`, with bits 7..1 set to 0.
- R6: A byte write (op 3) sends `cmd_wdata` as eight back-to-back write slots, least significant bit first, with no idle cycle between slots.
- R7: A byte read (op 4) runs eight back-to-back read slots. Each new bit enters at `rd_data[7]` while earlier bits shift right, so the first bit received ends up in bit 0.
- R8: `busy` rises in the cycle after an accepted start. It stays high for exactly the total length of the operation's slots. `done` is high for one cycle, the first cycle in which `busy` is low again. Op 0 selects a bus reset.
- R9: A start while `busy` is high is ignored. A start with op codes 5, 6 or 7 is ignored and leaves `busy` and `line_oe` low.
- R10: After reset, `line_oe`, `busy` and `done` are 0, `presence_n` is 1 and `rd_data` is 0. `line_oe` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Launch the operation on `cmd_op` when idle |
| cmd_op | input | 3 | 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_wdata | input | 8 | Bit (bit 0) or byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| rd_data | output | 8 | Result of the last read |
| presence_n | output | 1 | Result of the last bus reset, 1 = no device |
| line_oe | output | 1 | 1 pulls the bus line low, 0 releases it |
| line_in | input | 1 | Bus line level |

## Verification
The in-RTL assertions watch a set of rules on every cycle:
- `line_oe` is high only during an operation.
- A pull starts only when a slot is launched.
- A new slot is launched only when the engine is idle or in the last cycle of a slot.
- `busy` drops only together with `done`.
- `busy` cannot end in the middle of a slot.

The exact number of low and released cycles in each slot type, the bit order of byte transfers, and the values sampled for presence and read data depend on the whole sequence. Only the bench's per-cycle reference model shows these. It does so by replaying reset, bit and byte operations against a modelled device that pulls the line low in planned windows.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SK_RST = 2'd0,
    SK_W1  = 2'd1,
    SK_W0  = 2'd2,
    SK_RD  = 2'd3
  } slot_e;

  // Slot timing in microseconds
  localparam int RST_LOW_US  = 480;
  localparam int RST_SMP_US  = 70;
  localparam int RST_TOT_US  = 960;
  localparam int W1_LOW_US   = 6;
  localparam int W0_LOW_US   = 60;
  localparam int RD_LOW_US   = 6;
  localparam int RD_SMP_US   = 9;
  localparam int BIT_TOT_US  = 70;

  function automatic logic op_valid(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic slot_e kind_of(input logic [2:0] op, input logic b);
    case (op)
      OP_RESET:           return SK_RST;
      OP_RBIT, OP_RBYTE:  return SK_RD;
      default:            return b ? SK_W1 : SK_W0;
    endcase
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int CYC_PER_US = 200
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  slot_e kind,
  input  logic  line_s,
  output logic  oe,
  output logic  last,
  output logic  smp
);
  localparam int CW = $clog2(RST_TOT_US*CYC_PER_US + 1);
  localparam logic [CW-1:0] RST_LOW = CW'(RST_LOW_US*CYC_PER_US);
  localparam logic [CW-1:0] RST_SMP = CW'((RST_LOW_US+RST_SMP_US)*CYC_PER_US);
  localparam logic [CW-1:0] RST_TOT = CW'(RST_TOT_US*CYC_PER_US);
  localparam logic [CW-1:0] W1_LOW  = CW'(W1_LOW_US*CYC_PER_US);
  localparam logic [CW-1:0] W0_LOW  = CW'(W0_LOW_US*CYC_PER_US);
  localparam logic [CW-1:0] RD_LOW  = CW'(RD_LOW_US*CYC_PER_US);
  localparam logic [CW-1:0] RD_SMP  = CW'((RD_LOW_US+RD_SMP_US)*CYC_PER_US);
  localparam logic [CW-1:0] BIT_TOT = CW'(BIT_TOT_US*CYC_PER_US);

  logic          active;
  logic [CW-1:0] cnt;
  slot_e         kind_q;
  logic [CW-1:0] low_c, smp_c, tot_c;

  always_comb begin
    case (kind_q)
      SK_RST:  begin low_c = RST_LOW; smp_c = RST_SMP; tot_c = RST_TOT; end
      SK_W1:   begin low_c = W1_LOW;  smp_c = '0;      tot_c = BIT_TOT; end
      SK_W0:   begin low_c = W0_LOW;  smp_c = '0;      tot_c = BIT_TOT; end
      default: begin low_c = RD_LOW;  smp_c = RD_SMP;  tot_c = BIT_TOT; end
    endcase
  end

  assign last = active && (cnt == tot_c - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      kind_q <= SK_RST;
      oe     <= 1'b0;
      smp    <= 1'b1;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= '0;
      kind_q <= kind;
      oe     <= 1'b1;
    end else if (active) begin
      if (cnt == smp_c) smp <= line_s;
      if (last) begin
        active <= 1'b0;
        oe     <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        oe  <= (cnt + CW'(1)) < low_c;
      end
    end
  end

  // R8: a new slot is launched only when idle or at the final cycle of one
  a_r8_go_when_free: assert property (@(posedge clk) disable iff (rst)
    go |-> (!active || last));
  // R1: a pull on the line begins only when a slot is launched
  a_r1_pull_from_go: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(go));
endmodule

// File: rtl/owm_sequencer.sv
module owm_sequencer
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_start,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       last,
  input  logic       smp,
  output logic       go,
  output slot_e      kind,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       presence_n
);
  logic [2:0] op_q;
  logic [7:0] sh;
  logic [2:0] bits_left;
  logic [7:0] acc, acc_next;
  logic       accept, more;

  always_comb begin
    accept   = cmd_start && !busy && op_valid(cmd_op);
    more     = last && (bits_left != 3'd0);
    go       = accept || more;
    kind     = accept ? kind_of(cmd_op, cmd_wdata[0]) : kind_of(op_q, sh[1]);
    acc_next = {smp, acc[7:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      op_q       <= OP_RESET;
      sh         <= '0;
      bits_left  <= '0;
      acc        <= '0;
      rd_data    <= '0;
      presence_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        op_q      <= cmd_op;
        sh        <= cmd_wdata;
        bits_left <= (cmd_op == OP_WBYTE || cmd_op == OP_RBYTE) ? 3'd7 : 3'd0;
      end else if (last) begin
        acc <= acc_next;
        if (more) begin
          bits_left <= bits_left - 3'd1;
          sh        <= sh >> 1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
          case (op_q)
            OP_RESET: presence_n <= smp;
            OP_RBIT:  rd_data    <= {7'b0, smp};
            OP_RBYTE: rd_data    <= acc_next;
            default:  ;
          endcase
        end
      end
    end
  end

  // R8: busy only drops together with the done pulse
  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: nothing ends an operation except the end of its final slot
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int CYC_PER_US  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_start,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       presence_n,
  output logic       line_oe,
  input  logic       line_in
);
  logic  line_s, go, last, smp;
  slot_e kind;

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  owm_slot_engine #(.CYC_PER_US(CYC_PER_US)) u_engine (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .line_s(line_s),
    .oe(line_oe), .last(last), .smp(smp)
  );

  owm_sequencer u_seq (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .last(last), .smp(smp), .go(go), .kind(kind),
    .busy(busy), .done(done), .rd_data(rd_data), .presence_n(presence_n)
  );

  // R10: the line is pulled only during an operation
  a_r10_oe_in_op: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);
endmodule

// File: tb/test_onewire_master.sv
module test_onewire_master;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int C = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_start = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       busy, done, presence_n, line_oe, line_in;
  logic [7:0] rd_data;
  logic       dev_pull = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Reference model state
  bit    q_oe[$];
  bit    q_pull[$];
  bit    exp_oe = 1'b0, exp_busy = 1'b0, exp_done = 1'b0;
  string cur_tag = "R8";
  bit       plan_present = 1'b0;
  bit [7:0] plan_bits = 8'd0;

  always #2.5 clk = ~clk;

  assign line_in = !(line_oe || dev_pull);

  onewire_master #(.CYC_PER_US(C)) i_onewire_master (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .presence_n(presence_n), .line_oe(line_oe), .line_in(line_in)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_slot(input int low_us, input int tot_us,
                           input int pf_us, input int pt_us);
    for (int i = 0; i < tot_us*C; i++) begin
      q_oe.push_back(i < low_us*C);
      q_pull.push_back(i >= pf_us*C && i < pt_us*C);
    end
  endtask

  task automatic push_read(input bit b);
    if (b) push_slot(6, 70, 0, 0);
    else   push_slot(6, 70, 0, 36);
  endtask

  // Behavioural per-cycle model, stepped at each rising edge
  always @(posedge clk) begin
    bit popped;
    bit accept;
    popped = 1'b0;
    if (rst) begin
      q_oe.delete();
      q_pull.delete();
    end else begin
      if (q_oe.size() != 0) begin
        void'(q_oe.pop_front());
        void'(q_pull.pop_front());
        popped = 1'b1;
      end
      accept = cmd_start && !popped && (cmd_op <= 3'd4);
      if (accept) begin
        case (cmd_op)
          3'd0: begin cur_tag = "R1"; push_slot(480, 960, plan_present ? 495 : 0, plan_present ? 720 : 0); end
          3'd1: begin cur_tag = cmd_wdata[0] ? "R3" : "R4"; push_slot(cmd_wdata[0] ? 6 : 60, 70, 0, 0); end
          3'd2: begin cur_tag = "R5"; push_read(plan_bits[0]); end
          3'd3: begin cur_tag = "R6";
                  for (int i = 0; i < 8; i++) push_slot(cmd_wdata[i] ? 6 : 60, 70, 0, 0);
                end
          default: begin cur_tag = "R7";
                  for (int i = 0; i < 8; i++) push_read(plan_bits[i]);
                end
        endcase
      end
    end
    exp_done = popped && (q_oe.size() == 0);
    exp_busy = (q_oe.size() != 0);
    exp_oe   = (q_oe.size() != 0) ? q_oe[0] : 1'b0;
    dev_pull <= (q_pull.size() != 0) ? q_pull[0] : 1'b0;
  end

  // Compare every cycle away from the clock edge
  always @(negedge clk) begin
    if (!rst) begin
      check(line_oe == exp_oe, cur_tag, "line_oe", line_oe, exp_oe);
      check(busy == exp_busy, "R8", "busy", busy, exp_busy);
      check(done == exp_done, "R8", "done", done, exp_done);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [7:0] wd,
                        input bit present, input bit [7:0] bits, input bit inject);
    @(negedge clk);
    plan_present = present;
    plan_bits    = bits;
    cmd_op       = op;
    cmd_wdata    = wd;
    cmd_start    = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (inject) begin
      // R9: a reset request in the middle of an operation must be ignored
      repeat (100) @(negedge clk);
      cmd_op    = 3'd0;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (exp_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(line_oe == 1'b0 && busy == 1'b0 && done == 1'b0, "R10", "idle outputs",
          {line_oe, busy, done}, 0);
    check(presence_n == 1'b1, "R10", "presence_n reset", presence_n, 1);
    check(rd_data == 8'h00, "R10", "rd_data reset", rd_data, 0);

    run_op(3'd0, 8'h00, 1'b1, 8'h00, 1'b0);
    check(presence_n == 1'b0, "R2", "presence with device", presence_n, 0);
    run_op(3'd0, 8'h00, 1'b0, 8'h00, 1'b0);
    check(presence_n == 1'b1, "R2", "presence without device", presence_n, 1);

    run_op(3'd1, 8'h01, 1'b0, 8'h00, 1'b0);
    run_op(3'd1, 8'hFE, 1'b0, 8'h00, 1'b0);

    run_op(3'd2, 8'h00, 1'b0, 8'h00, 1'b0);
    check(rd_data == 8'h00, "R5", "read bit 0", rd_data, 0);
    run_op(3'd2, 8'h00, 1'b0, 8'hFF, 1'b0);
    check(rd_data == 8'h01, "R5", "read bit 1", rd_data, 1);

    run_op(3'd3, 8'hA5, 1'b0, 8'h00, 1'b0);
    run_op(3'd3, 8'h3C, 1'b0, 8'h00, 1'b1);

    run_op(3'd4, 8'h00, 1'b0, 8'h5A, 1'b0);
    check(rd_data == 8'h5A, "R7", "read byte 5A", rd_data, 8'h5A);
    run_op(3'd4, 8'h00, 1'b0, 8'hC3, 1'b1);
    check(rd_data == 8'hC3, "R7", "read byte C3", rd_data, 8'hC3);

    // R9: invalid op codes start nothing
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      cmd_op    = 3'(k);
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && line_oe == 1'b0, "R9", "invalid op ignored",
            {busy, line_oe}, 0);
    end
    check(rd_data == 8'hC3, "R9", "rd_data kept after invalid op", rd_data, 8'hC3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule